// File: doc/BRIEF.md
# Event Performance Monitor Counters

This block gives a processor core a small bank of event counters for profiling. The core presents a vector of one-cycle event strobes. Each counter has its own 8-bit selector, which picks one strobe from that vector, and the counter adds one in every enabled cycle in which the chosen strobe is high. A single global enable starts and stops all counting at once. A counter that rolls over from all ones to zero latches a sticky overflow flag and then keeps counting. The flag, gated by that counter's interrupt-enable bit, raises a level-sensitive interrupt request.

Software reaches the block through a simple word-addressed register port. Writes take effect on the next rising clock edge. Reads are combinational from the address. The overflow flags clear only when software writes ones to them. Clearing the global enable stops the counters but leaves the flags and any pending request in place. Selector value 0xFF, and any selector that names a strobe that does not exist, parks a counter so that it stays idle.

Top module: `evt_perf_monitor`

## Requirements
- R1: After reset, control, interrupt-enable, overflow-flag and all counter registers read 0, the event-select register reads 0xFFFFFFFF, and irq_o is low.
- R2: With the global enable set, counter k adds one in each cycle in which evt_i[v] is high, where v is the value in event-select bits [8k+7:8k].
- R3: With the global enable clear, no counter changes except through a software write to that counter.
- R4: When counter k steps from 0xFFFFFFFF to 0, overflow-flag bit k is set, and the counter goes on counting from 0.
- R5: Writing a one to overflow-flag bit k clears that flag. Writing a zero to a flag bit leaves it unchanged.
- R6: irq_o is high exactly when some counter has both its overflow flag and its interrupt-enable bit set.
- R7: Clearing interrupt-enable bit k removes counter k's part of irq_o, while its overflow flag stays set.
- R8: Clearing the global enable clears no overflow flag and does not drop irq_o.
- R9: Selector value 0xFF, and any selector value of NUM_EVT or more, makes that counter count nothing.
- R10: If software writes a one to flag k in the same cycle that counter k wraps, flag k ends up set.
- R11: A software write to a counter loads the written value. The write takes priority over an event in the same cycle, and counting resumes from the loaded value.
- R12: The register map uses byte offsets, decoded on address bits [4:2]. 0x00 is control (bit 0 is the global enable), 0x04 is interrupt enable (bits 3:0), 0x08 is the overflow flags (bits 3:0), 0x0C is event select, and 0x10, 0x14, 0x18 and 0x1C are counters 0 to 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_i | input | NUM_EVT | One-cycle event strobes from the core |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register byte address |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data for reg_addr_i |
| irq_o | output | 1 | Level-sensitive interrupt request |

## Verification
Every counter is tried with every selector value from 0 up to two past the last strobe, and with 0x80 and 0xFF. In the test, the selected strobe is high only on alternate cycles, while all other strobes take the opposite phase. A wrong field position or a wrong strobe index therefore gives a count that differs from the expected one, and an idle selector must give zero even while every other strobe is active. Each counter is then preloaded just below the wrap point to test the flag setting, the write-one-to-clear behaviour, the interrupt gating, the effect of the global enable, a clear that lands in the same cycle as a wrap, and a load that lands in the same cycle as an event.

// File: rtl/pmon_pkg.sv
// Package: shared register word indices for the performance monitor.
// Assumes byte addressing with 32-bit words, so the word index is addr[..:2].
package pmon_pkg;
    localparam int unsigned WIDX_CTRL  = 0;
    localparam int unsigned WIDX_INTEN = 1;
    localparam int unsigned WIDX_OVF   = 2;
    localparam int unsigned WIDX_EVSEL = 3;
    localparam int unsigned WIDX_CNT0  = 4;
endpackage

// File: rtl/pmon_event_mux.sv
// Module: pmon_event_mux
// Picks one event strobe from the core vector by an 8-bit selector.
// Assumes NUM_EVT < 2**SEL_W - 1, so the all-ones code never names a strobe
// and always parks the counter. Codes at or above NUM_EVT also give no hit.
module pmon_event_mux #(
    parameter int unsigned NUM_EVT = 16,
    parameter int unsigned SEL_W   = 8
) (
    input  logic [NUM_EVT-1:0] evt,
    input  logic [SEL_W-1:0]   sel,
    output logic               hit
);
    // Compare against every implemented index; unmatched codes give zero.
    always_comb begin
        hit = 1'b0;
        for (int i = 0; i < NUM_EVT; i++) begin
            if (sel == SEL_W'(i)) hit = evt[i];
        end
    end
endmodule

// File: rtl/pmon_counter.sv
// Module: pmon_counter
// One event counter with a sticky overflow flag.
// Assumes: a software load wins over an increment in the same cycle; a wrap
// in the same cycle as a flag clear leaves the flag set.
module pmon_counter #(
    parameter int unsigned CTR_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             hit,
    input  logic             ld,
    input  logic [CTR_W-1:0] ld_val,
    input  logic             flag_clr,
    output logic [CTR_W-1:0] cnt,
    output logic             ovf
);
    logic step;
    logic wrap;

    // Decide whether this cycle advances the count and whether it wraps.
    always_comb begin
        step = en && hit && !ld;
        wrap = step && (&cnt);
    end

    // Count register: load, increment or hold.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (ld)   cnt <= ld_val;
        else if (step) cnt <= cnt + CTR_W'(1);
    end

    // Sticky flag: a wrap sets it and wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)        ovf <= 1'b0;
        else if (wrap)     ovf <= 1'b1;
        else if (flag_clr) ovf <= 1'b0;
    end
endmodule

// File: rtl/evt_perf_monitor.sv
// Module: evt_perf_monitor (top)
// A bank of NUM_CTR event counters with per-counter event selectors, a global
// enable, sticky write-one-to-clear overflow flags, interrupt enables and one
// level interrupt. Assumes NUM_CTR*SEL_W <= DATA_W, CTR_W <= DATA_W and
// ADDR_W wide enough to reach the last counter word.
module evt_perf_monitor #(
    parameter int unsigned NUM_CTR = 4,
    parameter int unsigned CTR_W   = 32,
    parameter int unsigned SEL_W   = 8,
    parameter int unsigned NUM_EVT = 16,
    parameter int unsigned ADDR_W  = 5,
    parameter int unsigned DATA_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] evt_i,
    input  logic               reg_wr_i,
    input  logic [ADDR_W-1:0]  reg_addr_i,
    input  logic [DATA_W-1:0]  reg_wdata_i,
    output logic [DATA_W-1:0]  reg_rdata_o,
    output logic               irq_o
);
    import pmon_pkg::*;

    localparam int unsigned WIDX_W  = ADDR_W - 2;
    localparam int unsigned EVSEL_W = NUM_CTR * SEL_W;

    logic [WIDX_W-1:0]      widx;
    logic                   en_q;
    logic [NUM_CTR-1:0]     inten_q;
    logic [EVSEL_W-1:0]     evsel_q;
    logic [NUM_CTR-1:0]     ctr_hit;
    logic [NUM_CTR-1:0]     ctr_ld;
    logic [NUM_CTR-1:0]     flag_clr;
    logic [NUM_CTR-1:0]     ovf_flags;
    logic [CTR_W-1:0]       cnt_val [NUM_CTR];
    logic [NUM_CTR*CTR_W-1:0] cnt_flat;
    logic                   wr_ctrl, wr_inten, wr_ovf, wr_evsel;

    assign widx = reg_addr_i[ADDR_W-1:2];

    // Decode which configuration register a write targets.
    always_comb begin
        wr_ctrl  = reg_wr_i && (widx == WIDX_W'(WIDX_CTRL));
        wr_inten = reg_wr_i && (widx == WIDX_W'(WIDX_INTEN));
        wr_ovf   = reg_wr_i && (widx == WIDX_W'(WIDX_OVF));
        wr_evsel = reg_wr_i && (widx == WIDX_W'(WIDX_EVSEL));
    end

    // Configuration registers; selectors reset to the idle code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            inten_q <= '0;
            evsel_q <= '1;
        end else begin
            if (wr_ctrl)  en_q    <= reg_wdata_i[0];
            if (wr_inten) inten_q <= reg_wdata_i[NUM_CTR-1:0];
            if (wr_evsel) evsel_q <= reg_wdata_i[EVSEL_W-1:0];
        end
    end

    // One selector, counter and flag per slot.
    for (genvar k = 0; k < NUM_CTR; k++) begin : g_ctr
        pmon_event_mux #(.NUM_EVT(NUM_EVT), .SEL_W(SEL_W)) u_mux (
            .evt (evt_i),
            .sel (evsel_q[k*SEL_W +: SEL_W]),
            .hit (ctr_hit[k])
        );

        assign ctr_ld[k]   = reg_wr_i && (widx == WIDX_W'(WIDX_CNT0 + k));
        assign flag_clr[k] = wr_ovf && reg_wdata_i[k];

        pmon_counter #(.CTR_W(CTR_W)) u_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .en       (en_q),
            .hit      (ctr_hit[k]),
            .ld       (ctr_ld[k]),
            .ld_val   (reg_wdata_i[CTR_W-1:0]),
            .flag_clr (flag_clr[k]),
            .cnt      (cnt_val[k]),
            .ovf      (ovf_flags[k])
        );

        assign cnt_flat[k*CTR_W +: CTR_W] = cnt_val[k];
    end

    // Interrupt: any flag whose enable is set.
    assign irq_o = |(ovf_flags & inten_q);

    // Read mux by word index.
    always_comb begin
        reg_rdata_o = '0;
        if (widx == WIDX_W'(WIDX_CTRL))       reg_rdata_o = DATA_W'(en_q);
        else if (widx == WIDX_W'(WIDX_INTEN)) reg_rdata_o = DATA_W'(inten_q);
        else if (widx == WIDX_W'(WIDX_OVF))   reg_rdata_o = DATA_W'(ovf_flags);
        else if (widx == WIDX_W'(WIDX_EVSEL)) reg_rdata_o = DATA_W'(evsel_q);
        else begin
            for (int k = 0; k < NUM_CTR; k++) begin
                if (widx == WIDX_W'(WIDX_CNT0 + k)) reg_rdata_o = DATA_W'(cnt_val[k]);
            end
        end
    end
endmodule

// File: rtl/pmon_checker.sv
// Module: pmon_checker
// Timing properties of the counters, flags and interrupt, bound to the top.
module pmon_checker #(
    parameter int unsigned NUM_CTR = 4,
    parameter int unsigned CTR_W   = 32
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     en,
    input logic                     any_wr,
    input logic [NUM_CTR-1:0]       hit,
    input logic [NUM_CTR-1:0]       ld,
    input logic [NUM_CTR-1:0]       clr,
    input logic [NUM_CTR-1:0]       ovf,
    input logic [NUM_CTR*CTR_W-1:0] cnt,
    input logic                     irq
);
    // R1: a reset cycle leaves the request low.
    a_r1_reset_quiet: assert property (@(posedge clk) !rst_n |=> !irq);

    // R8: without a register write the request cannot drop.
    a_r8_irq_held: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !any_wr) |=> irq);

    for (genvar k = 0; k < NUM_CTR; k++) begin : g_chk
        // R2: an enabled hit advances the count by one.
        a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
            (en && hit[k] && !ld[k]) |=>
            cnt[k*CTR_W +: CTR_W] == $past(cnt[k*CTR_W +: CTR_W]) + CTR_W'(1));

        // R3: with counting off and no load the count holds.
        a_r3_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
            (!en && !ld[k]) |=> $stable(cnt[k*CTR_W +: CTR_W]));

        // R4: a wrap sets the flag.
        a_r4_wrap_sets: assert property (@(posedge clk) disable iff (!rst_n)
            (en && hit[k] && !ld[k] && (&cnt[k*CTR_W +: CTR_W])) |=> ovf[k]);

        // R5: a flag stays set until a one is written to it.
        a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (ovf[k] && !clr[k]) |=> ovf[k]);

        // R10: a clear that meets a wrap loses.
        a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[k] && en && hit[k] && !ld[k] && (&cnt[k*CTR_W +: CTR_W])) |=> ovf[k]);
    end
endmodule

bind evt_perf_monitor pmon_checker #(.NUM_CTR(NUM_CTR), .CTR_W(CTR_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (en_q),
    .any_wr (reg_wr_i),
    .hit    (ctr_hit),
    .ld     (ctr_ld),
    .clr    (flag_clr),
    .ovf    (ovf_flags),
    .cnt    (cnt_flat),
    .irq    (irq_o)
);

// File: tb/evt_perf_monitor_tb.sv
// Bench: sweeps selectors over every counter, then walks each counter through
// wrap, flag, interrupt, enable and same-cycle corner cases.
module evt_perf_monitor_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NUM_EVT    = 16;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [NUM_EVT-1:0] evt_i = '0;
    logic               reg_wr_i = 1'b0;
    logic [4:0]         reg_addr_i = '0;
    logic [31:0]        reg_wdata_i = '0;
    logic [31:0]        reg_rdata_o;
    logic               irq_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    evt_perf_monitor #(.NUM_EVT(NUM_EVT)) u_dut (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .reg_wr_i(reg_wr_i),
        .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
        .reg_rdata_o(reg_rdata_o), .irq_o(irq_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
        @(negedge clk);
        reg_wr_i = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        reg_addr_i = a;
        #1;
        d = reg_rdata_o;
    endtask

    task automatic pulse_evt0();
        @(negedge clk); evt_i = 'd1;
        @(negedge clk); evt_i = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;

        // R1 / R12: reset values through the map
        for (int w = 0; w < 8; w++) begin
            rd(5'(w*4), d);
            check("R1 reset value", d, (w == 3) ? 32'hFFFF_FFFF : 32'h0);
        end
        check("R1 reset irq", 32'(irq_o), 32'h0);

        // R2 / R9: selector sweep on every counter
        for (int k = 0; k < 4; k++) begin
            for (int s = 0; s < NUM_EVT + 4; s++) begin
                int v;
                logic [NUM_EVT-1:0] one;
                int exp;
                v = (s < NUM_EVT + 2) ? s : ((s == NUM_EVT + 2) ? 8'h80 : 8'hFF);
                one = '0;
                if (v < NUM_EVT) one[v] = 1'b1;
                wr(5'(16 + 4*k), 32'h0);
                wr(5'h0C, (32'hFFFF_FFFF & ~(32'hFF << (8*k))) | (32'(v) << (8*k)));
                wr(5'h00, 32'h1);
                for (int c = 0; c < 7; c++) begin
                    @(negedge clk);
                    evt_i = (c % 2 == 1) ? one : ~one;
                end
                @(negedge clk); evt_i = '0;
                wr(5'h00, 32'h0);
                rd(5'(16 + 4*k), d);
                exp = (v < NUM_EVT) ? 3 : 0;
                if (v < NUM_EVT) check("R2 selected event count", d, 32'(exp));
                else             check("R9 idle selector count", d, 32'(exp));
            end
        end

        // R4..R11 per counter
        for (int k = 0; k < 4; k++) begin
            logic [31:0] bit_k;
            bit_k = 32'h1 << k;
            wr(5'h0C, (32'hFFFF_FFFF & ~(32'hFF << (8*k))));
            wr(5'h08, 32'hF);
            wr(5'h04, 32'h0);
            wr(5'(16 + 4*k), 32'hFFFF_FFFE);
            wr(5'h00, 32'h1);
            pulse_evt0();
            rd(5'(16 + 4*k), d); check("R2 count before wrap", d, 32'hFFFF_FFFF);
            rd(5'h08, d);        check("R4 no flag before wrap", d, 32'h0);
            pulse_evt0();
            rd(5'(16 + 4*k), d); check("R4 wrapped to zero", d, 32'h0);
            rd(5'h08, d);        check("R4 flag set on wrap", d, bit_k);
            check("R6 irq low while disabled", 32'(irq_o), 32'h0);
            pulse_evt0();
            rd(5'(16 + 4*k), d); check("R4 counts on after wrap", d, 32'h1);
            wr(5'h04, bit_k); #1;
            check("R6 irq high with flag and enable", 32'(irq_o), 32'h1);
            wr(5'h04, 32'h0); #1;
            check("R7 irq dropped by enable clear", 32'(irq_o), 32'h0);
            rd(5'h08, d);        check("R7 flag kept", d, bit_k);
            wr(5'h04, bit_k);
            wr(5'h00, 32'h0); #1;
            check("R8 irq kept when counting off", 32'(irq_o), 32'h1);
            rd(5'h08, d);        check("R8 flag kept when counting off", d, bit_k);
            rd(5'h00, d);        check("R12 control reads back", d, 32'h0);
            wr(5'h08, ~bit_k & 32'hF);
            rd(5'h08, d);        check("R5 zero write ignored", d, bit_k);
            wr(5'h08, bit_k); #1;
            rd(5'h08, d);        check("R5 one write clears", d, 32'h0);
            check("R6 irq low after clear", 32'(irq_o), 32'h0);

            // R10: clear in the wrap cycle
            wr(5'(16 + 4*k), 32'hFFFF_FFFF);
            wr(5'h00, 32'h1);
            pulse_evt0();
            wr(5'(16 + 4*k), 32'hFFFF_FFFF);
            @(negedge clk);
            reg_wr_i = 1'b1; reg_addr_i = 5'h08; reg_wdata_i = bit_k; evt_i = 'd1;
            @(negedge clk);
            reg_wr_i = 1'b0; evt_i = '0;
            rd(5'h08, d);        check("R10 flag set wins over clear", d, bit_k);
            rd(5'(16 + 4*k), d); check("R10 counter wrapped", d, 32'h0);

            // R11: load in the same cycle as an event
            @(negedge clk);
            reg_wr_i = 1'b1; reg_addr_i = 5'(16 + 4*k); reg_wdata_i = 32'd100; evt_i = 'd1;
            @(negedge clk);
            reg_wr_i = 1'b0;
            @(negedge clk); evt_i = '0;
            rd(5'(16 + 4*k), d); check("R11 load then count", d, 32'd101);

            // R3: counting off holds
            wr(5'h00, 32'h0);
            @(negedge clk); evt_i = '1;
            repeat (5) @(negedge clk);
            evt_i = '0;
            rd(5'(16 + 4*k), d); check("R3 held while off", d, 32'd101);
            wr(5'h08, 32'hF);
            wr(5'h04, 32'h0);
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule